// File: doc/BRIEF.md
# Low-Bit Substituting Adder with Error Interval

This block adds two unsigned operands of independent widths after replacing a chosen number of each operand's lowest bits with a constant. For each operand, a count input selects how many low bits are forced, and a fill input selects whether the forced bits are all zeros or all ones. The binary point sits at the right-hand end of both operands, so no alignment step is needed. Forced bits are fixed values rather than live signals, so downstream logic can collapse them into wiring.

Next to the sum, the block reports a signed interval `[err_lo_o, err_hi_o]`. Error is defined as the exact sum of the unmodified operands minus the reported sum. For any operand values, the error is guaranteed to lie inside this interval.

Zero fill biases the error upward. One fill biases it downward. Mixing the two fills centres the interval around zero, so a design can compare precision choices by their worst-case error. The block is purely combinational.

Top module: `lsbsub_adder`

## Requirements
- R1: Bit i of operand A (0 ≤ i < effective count) is replaced by the fill value, where the fill value is 0 when `a_fill_ones_i`=0 and 1 when `a_fill_ones_i`=1. Bits at or above the effective count pass unchanged. Operand B behaves the same way with its own count and fill inputs.
- R2: `sum_o` is max(A_W,B_W)+1 bits wide and equals the exact unsigned sum of the two substituted operands, with no carry lost.
- R3: An operand whose count is 0 passes unmodified and contributes 0 to both error bounds.
- R4: A zero-filled operand with effective count p contributes the error range 0 to 2^p−1.
- R5: A one-filled operand with effective count p contributes the error range −(2^p−1) to 0.
- R6: `err_lo_o` and `err_hi_o` are the sums of the two operands' contributions. For every input, (a_i + b_i − sum_o) lies within [err_lo_o, err_hi_o].
- R7: A count larger than its operand width acts as the full operand width.
- R8: Let k be the smaller of the two effective counts. If both operands use zero fill, the lowest k bits of `sum_o` are 0. If exactly one operand uses one fill, the lowest k bits of `sum_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | A_W | Operand A, exact value |
| b_i | input | B_W | Operand B, exact value |
| a_cnt_i | input | $clog2(A_W+1) | Number of low bits of A to replace |
| b_cnt_i | input | $clog2(B_W+1) | Number of low bits of B to replace |
| a_fill_ones_i | input | 1 | Fill for A: 0 = zeros, 1 = ones |
| b_fill_ones_i | input | 1 | Fill for B: 0 = zeros, 1 = ones |
| sum_o | output | max(A_W,B_W)+1 | Sum of the substituted operands |
| err_lo_o | output | max(A_W,B_W)+2 | Signed lower error bound |
| err_hi_o | output | max(A_W,B_W)+2 | Signed upper error bound |

## Verification
The block has no state, so any internal fault shows at the ports as soon as the inputs settle.

A wrong substitution mask or fill value appears as a wrong sum, and as broken low bits in the zero-fill and mixed-fill cases. A broken carry cell shows as a sum that is wrong only for certain operand patterns, so the random sweep is what exposes it. A faulty bound calculation shows as an exact-sum error falling outside the reported interval, or as a nonzero bound when the count is zero.

// File: rtl/lsbsub_pkg.sv
package lsbsub_pkg;

  // Effective substitution count: requests beyond the operand width saturate.
  function automatic int unsigned sat_count(input int unsigned req,
                                            input int unsigned width);
    return (req > width) ? width : req;
  endfunction

  function automatic int unsigned max_u(input int unsigned x,
                                        input int unsigned y);
    return (x > y) ? x : y;
  endfunction

  function automatic int unsigned min_u(input int unsigned x,
                                        input int unsigned y);
    return (x < y) ? x : y;
  endfunction

  // Magnitude of the widest error one operand can carry: 2^cnt - 1.
  function automatic longint unsigned fill_span(input int unsigned cnt);
    return (64'd1 << cnt) - 64'd1;
  endfunction

endpackage

// File: rtl/lsbsub_quant.sv
module lsbsub_quant #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  raw_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          ones_i,
  output logic [W-1:0]  quant_o,
  output logic [CW-1:0] eff_cnt_o
);
  import lsbsub_pkg::*;

  logic [W-1:0] keep_mask;

  assign eff_cnt_o = CW'(sat_count(32'(cnt_i), W));

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign keep_mask[i] = (CW'(i) >= eff_cnt_o);
    assign quant_o[i]   = keep_mask[i] ? raw_i[i] : ones_i;
  end

  always_comb begin
    // R3
    passthrough_chk : assert ((eff_cnt_o != '0) || (quant_o == raw_i))
      else $error("operand altered with zero substitution count");
    // R7
    cnt_range_chk : assert (32'(eff_cnt_o) <= W)
      else $error("effective count exceeds operand width");
  end

endmodule

// File: rtl/lsbsub_bound.sv
module lsbsub_bound #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = $clog2(W + 1),
  parameter int unsigned EW = W + 2
) (
  input  logic [CW-1:0]        eff_cnt_i,
  input  logic                 ones_i,
  output logic signed [EW-1:0] lo_o,
  output logic signed [EW-1:0] hi_o
);

  logic [EW-1:0] span;

  assign span = (EW'(1) << eff_cnt_i) - EW'(1);
  assign lo_o = ones_i ? -$signed(span) : '0;
  assign hi_o = ones_i ? '0 : $signed(span);

  always_comb begin
    // R3
    zero_cnt_err_chk : assert ((eff_cnt_i != '0) || ((lo_o == '0) && (hi_o == '0)))
      else $error("nonzero error bound for unsubstituted operand");
    // R4
    bound_order_chk : assert ((lo_o <= 0) && (hi_o >= 0))
      else $error("operand error interval excludes zero");
  end

endmodule

// File: rtl/lsbsub_ripple.sv
module lsbsub_ripple #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W:0]   s_o
);

  logic [W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic half_sum;
    assign half_sum   = x_i[i] ^ y_i[i];
    assign s_o[i]     = half_sum ^ carry[i];
    assign carry[i+1] = (x_i[i] & y_i[i]) | (half_sum & carry[i]);
  end

  assign s_o[W] = carry[W];

  always_comb begin
    // R2
    no_overflow_chk : assert (s_o == ({1'b0, x_i} + {1'b0, y_i}))
      else $error("carry chain result differs from arithmetic sum");
  end

endmodule

// File: rtl/lsbsub_adder.sv
module lsbsub_adder #(
  parameter int unsigned A_W    = 8,
  parameter int unsigned B_W    = 6,
  parameter int unsigned ACNT_W = $clog2(A_W + 1),
  parameter int unsigned BCNT_W = $clog2(B_W + 1),
  parameter int unsigned MAX_W  = (A_W > B_W) ? A_W : B_W,
  parameter int unsigned SUM_W  = MAX_W + 1,
  parameter int unsigned ERR_W  = MAX_W + 2
) (
  input  logic [A_W-1:0]          a_i,
  input  logic [B_W-1:0]          b_i,
  input  logic [ACNT_W-1:0]       a_cnt_i,
  input  logic [BCNT_W-1:0]       b_cnt_i,
  input  logic                    a_fill_ones_i,
  input  logic                    b_fill_ones_i,
  output logic [SUM_W-1:0]        sum_o,
  output logic signed [ERR_W-1:0] err_lo_o,
  output logic signed [ERR_W-1:0] err_hi_o
);
  import lsbsub_pkg::*;

  logic [A_W-1:0]          a_quant;
  logic [B_W-1:0]          b_quant;
  logic [ACNT_W-1:0]       a_eff;
  logic [BCNT_W-1:0]       b_eff;
  logic signed [ERR_W-1:0] a_lo, a_hi, b_lo, b_hi;
  logic [MAX_W-1:0]        a_ext, b_ext;

  lsbsub_quant #(.W(A_W), .CW(ACNT_W)) a_quant_i (
    .raw_i(a_i), .cnt_i(a_cnt_i), .ones_i(a_fill_ones_i),
    .quant_o(a_quant), .eff_cnt_o(a_eff)
  );

  lsbsub_quant #(.W(B_W), .CW(BCNT_W)) b_quant_i (
    .raw_i(b_i), .cnt_i(b_cnt_i), .ones_i(b_fill_ones_i),
    .quant_o(b_quant), .eff_cnt_o(b_eff)
  );

  lsbsub_bound #(.W(A_W), .CW(ACNT_W), .EW(ERR_W)) a_bound_i (
    .eff_cnt_i(a_eff), .ones_i(a_fill_ones_i), .lo_o(a_lo), .hi_o(a_hi)
  );

  lsbsub_bound #(.W(B_W), .CW(BCNT_W), .EW(ERR_W)) b_bound_i (
    .eff_cnt_i(b_eff), .ones_i(b_fill_ones_i), .lo_o(b_lo), .hi_o(b_hi)
  );

  assign a_ext = MAX_W'(a_quant);
  assign b_ext = MAX_W'(b_quant);

  lsbsub_ripple #(.W(MAX_W)) sum_i (
    .x_i(a_ext), .y_i(b_ext), .s_o(sum_o)
  );

  assign err_lo_o = a_lo + b_lo;
  assign err_hi_o = a_hi + b_hi;

  // Internal events brought out for the checks below.
  logic signed [ERR_W:0] exact_minus_sum;
  logic [SUM_W-1:0]      low_mask;
  int unsigned           overlap_cnt;

  assign exact_minus_sum = $signed({2'b00, SUM_W'(a_i) + SUM_W'(b_i)})
                         - $signed({2'b00, sum_o});
  assign overlap_cnt     = min_u(32'(a_eff), 32'(b_eff));
  assign low_mask        = SUM_W'((64'd1 << overlap_cnt) - 64'd1);

  always_comb begin
    // R6
    err_window_chk : assert ((exact_minus_sum >= (ERR_W+1)'(err_lo_o)) &&
                             (exact_minus_sum <= (ERR_W+1)'(err_hi_o)))
      else $error("sum error outside reported interval");
    // R8
    low_const_chk : assert ((a_fill_ones_i && b_fill_ones_i) ||
                            ((sum_o & low_mask) ==
                             ((a_fill_ones_i ^ b_fill_ones_i) ? low_mask : '0)))
      else $error("low sum bits not constant under overlap");
  end

endmodule

// File: tb/lsbsub_adder_tb.sv
module lsbsub_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int BW = 6;
  localparam int SW = 9;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] a;
  logic [BW-1:0] b;
  logic [3:0] a_cnt;
  logic [2:0] b_cnt;
  logic a_one, b_one;
  logic [SW-1:0] sum;
  logic signed [9:0] elo, ehi;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  lsbsub_adder dut_i (
    .a_i(a), .b_i(b), .a_cnt_i(a_cnt), .b_cnt_i(b_cnt),
    .a_fill_ones_i(a_one), .b_fill_ones_i(b_one),
    .sum_o(sum), .err_lo_o(elo), .err_hi_o(ehi)
  );

  function automatic longint m_eff(longint c, longint w);
    return (c > w) ? w : c;
  endfunction

  function automatic longint m_quant(longint v, longint c, bit ones, longint w);
    longint e = m_eff(c, w);
    longint low = (longint'(1) << e) - 1;
    return ones ? (v | low) : (v & ~low);
  endfunction

  function automatic longint m_span(longint c, longint w);
    return (longint'(1) << m_eff(c, w)) - 1;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input longint va, input longint vb, input longint ca,
                       input longint cb, input bit oa, input bit ob);
    @(negedge clk);
    a = AW'(va); b = BW'(vb); a_cnt = 4'(ca); b_cnt = 3'(cb);
    a_one = oa; b_one = ob;
    #1;
  endtask

  task automatic check_all(input string tag);
    longint qa = m_quant(longint'(a), longint'(a_cnt), a_one, AW);
    longint qb = m_quant(longint'(b), longint'(b_cnt), b_one, BW);
    longint sa = m_span(longint'(a_cnt), AW);
    longint sb = m_span(longint'(b_cnt), BW);
    longint lo = (a_one ? -sa : 0) + (b_one ? -sb : 0);
    longint hi = (a_one ? 0 : sa) + (b_one ? 0 : sb);
    longint d  = longint'(a) + longint'(b) - longint'(sum);
    check(longint'(sum) == qa + qb, {tag, " R1 R2 sum"}, longint'(sum), qa + qb);
    check(longint'(elo) == lo, {tag, " R4 R5 err_lo"}, longint'(elo), lo);
    check(longint'(ehi) == hi, {tag, " R4 R5 err_hi"}, longint'(ehi), hi);
    check(d >= lo && d <= hi, {tag, " R6 window"}, d, hi);
  endtask

  task automatic t_passthrough();
    apply(200, 63, 0, 0, 1, 1);
    check(sum == 9'd263, "R3 passthrough sum", longint'(sum), 263);
    check(elo == 0 && ehi == 0, "R3 zero bounds", longint'(ehi), 0);
    check_all("R3");
    apply(255, 63, 0, 0, 0, 0);
    check(sum == 9'd318, "R2 full carry out", longint'(sum), 318);
  endtask

  task automatic t_zero_fill();
    apply(8'hB7, 6'h2D, 3, 2, 0, 0);
    check(sum == 9'(8'hB0 + 6'h2C), "R1 zero fill sum", longint'(sum), 8'hB0 + 6'h2C);
    check(elo == 0 && ehi == 10'sd10, "R4 bound 0..2^3+2^2-2", longint'(ehi), 10);
    check((sum & 9'h3) == 0, "R8 zero fill low bits", longint'(sum & 9'h3), 0);
    check_all("R4");
  endtask

  task automatic t_one_fill();
    apply(8'h40, 6'h01, 4, 0, 1, 0);
    check(sum == 9'h50, "R5 ones fill sum", longint'(sum), 'h50);
    check(elo == -10'sd15 && ehi == 0, "R5 bound -(2^4-1)..0", longint'(elo), -15);
    apply(8'h12, 6'h21, 2, 3, 1, 0);
    check(elo == -10'sd3 && ehi == 10'sd7, "R5 mixed bound", longint'(ehi), 7);
    check((sum & 9'h3) == 9'h3, "R8 mixed fill low bits", longint'(sum & 9'h3), 3);
    check_all("R5");
  endtask

  task automatic t_saturate();
    apply(8'hFF, 6'h3F, 15, 7, 0, 0);
    check(sum == 0, "R7 saturated zero sum", longint'(sum), 0);
    check(ehi == 10'sd318, "R7 saturated hi", longint'(ehi), 318);
    apply(8'h00, 6'h00, 9, 7, 1, 1);
    check(sum == 9'd318, "R7 saturated ones sum", longint'(sum), 318);
    check(elo == -10'sd318, "R7 saturated lo", longint'(elo), -318);
  endtask

  task automatic t_random();
    for (int k = 0; k < 300; k++) begin
      apply($urandom_range(255), $urandom_range(63), $urandom_range(10),
            $urandom_range(7), 1'($urandom), 1'($urandom));
      check_all("R6 random");
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    a = '0; b = '0; a_cnt = '0; b_cnt = '0; a_one = 0; b_one = 0;
    #2;
    check(sum == 0 && elo == 0 && ehi == 0, "R3 idle state", longint'(sum), 0);
    t_passthrough();
    t_zero_fill();
    t_one_fill();
    t_saturate();
    t_random();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule